// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block decides, cycle by cycle, whether the instruction sitting in decode of an in-order pipeline may move on into execute. Execute fans out into four pipelined units and one unpipelined divider. The pipelined units are integer (one stage), load (two stages), floating-point add (four stages) and multiply (seven stages). The divider holds one operation for 24 cycles. Each class has its own result latency, so results come back out of order. The interlock therefore keeps a record of what is in flight in every stage and of the future write-back cycles already promised to the single register-file write port.

Each cycle decode presents the following:
- a unit class;
- a destination register index and two source register indices, each with a use flag.

The block answers with an issue or a stall. A stall carries a cause vector that names every hazard found. When decode stalls, nothing enters any unit stage that cycle. The block also raises a strobe in each cycle in which a scheduled write-back takes place, so the write-back schedule can be seen at the ports. No WAR check is made, because operands are read in decode.

Top module: `ilk_issue_interlock`

## Requirements
- R1: After a synchronous active-low reset nothing is in flight, the divider is free and no write-back slot is booked. Any valid instruction issues in the first cycle after reset, and `wb_now` is low.
- R2: `issue` = `dec_valid` and no hazard. `stall` = `dec_valid` and at least one hazard. The bits of `stall_cause` are: bit0 divider busy, bit1 RAW, bit2 WAW, bit3 write-port conflict. Several bits may be set at once. All three outputs are zero when `dec_valid` is low.
- R3: The divider accepts a new operation no sooner than 25 cycles after the previous one. A divide presented while it is busy stalls with cause bit0.
- R4: A producer issued in cycle t with result latency L blocks any instruction that reads its destination in cycles t+1 to t+L (cause bit1). The reader may issue in cycle t+L+1. L is 0 for class 0 (integer), 1 for class 1 (load), 3 for class 2 (FP add), 6 for class 3 (multiply) and 24 for class 4 (divide). Codes 5 to 7 act as integer.
- R5: An instruction whose destination equals the destination of any instruction still inside a unit stage, or still inside the divider, stalls with cause bit2.
- R6: An instruction with a used destination issued in cycle t writes back in cycle t+L+2, and `wb_now` is high in that cycle. If that cycle is already booked, the instruction stalls with cause bit3.
- R7: A source or destination field whose use flag is low never causes a hazard. An unused destination books no write-back slot.
- R8: A stalled instruction leaves nothing in any unit stage and books no write-back slot. If decode replaces it, it leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_cls | input | 3 | Unit class code (R4) |
| dec_dst | input | 5 | Destination register index |
| dec_dst_en | input | 1 | Destination is used |
| dec_src1 | input | 5 | First source register index |
| dec_src1_en | input | 1 | First source is used |
| dec_src2 | input | 5 | Second source register index |
| dec_src2_en | input | 1 | Second source is used |
| issue | output | 1 | Instruction moves to execute this cycle |
| stall | output | 1 | Instruction is held in decode |
| stall_cause | output | 4 | Hazard flags (R2) |
| wb_now | output | 1 | A booked write-back happens this cycle |

## Verification
The bench measures the exact stall length for a reader behind each producer class, latency 0 through 24. A RAW window that is off by one would release the reader one cycle early or hold it one cycle too long. It checks the last cycle of divider occupancy, and it checks a WAW stall that also meets a write-port collision midway, so the cause vector must show both bits. It checks a load followed by an integer write to the same write-back cycle, and a replaced stalled instruction. A design that pushes stalled entries into a unit or books their slot would produce a false WAW stall or a stray `wb_now` pulse there.

// File: rtl/ilk_pkg.sv
// Shared types and constants for the issue interlock.
// Assumes a 32-entry register file indexed by 5 bits.
package ilk_pkg;

    localparam int REG_W = 5;

    // Unit class codes presented by decode; codes above CLS_DIV act as integer.
    typedef enum logic [2:0] {
        CLS_INT  = 3'd0,
        CLS_LOAD = 3'd1,
        CLS_FADD = 3'd2,
        CLS_MUL  = 3'd3,
        CLS_DIV  = 3'd4
    } unit_cls_e;

    // Bit positions of the stall cause vector.
    localparam int CAUSE_BUSY = 0;
    localparam int CAUSE_RAW  = 1;
    localparam int CAUSE_WAW  = 2;
    localparam int CAUSE_WBP  = 3;
    localparam int CAUSE_W    = 4;

    // One tracked execute-stage slot.
    typedef struct packed {
        logic             vld;
        logic             dst_en;
        logic [REG_W-1:0] dst;
    } trk_entry_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilk_stage_pipe.sv
// Tracker for one pipelined functional unit.
// Holds a valid bit and destination for each of DEPTH stages; every stage
// advances each cycle (execute never back-pressures). Reports a RAW hit
// against the first RAW_STAGES stages (results not yet forwardable) and a
// WAW hit against every stage. Assumes push is low whenever issue stalls.
module ilk_stage_pipe
    import ilk_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int RAW_STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_dst_en,
    input  logic [REG_W-1:0] push_dst,
    input  logic [REG_W-1:0] q_src1,
    input  logic             q_src1_en,
    input  logic [REG_W-1:0] q_src2,
    input  logic             q_src2_en,
    input  logic [REG_W-1:0] q_dst,
    input  logic             q_dst_en,
    output logic             raw_hit,
    output logic             waw_hit
);

    trk_entry_t stg_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stg
        if (s == 0) begin : g_head
            // Entry stage: takes the issuing instruction or a bubble.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else begin
                    stg_q[s].vld    <= push;
                    stg_q[s].dst_en <= push & push_dst_en;
                    stg_q[s].dst    <= push_dst;
                end
            end
        end else begin : g_body
            // Later stages: plain shift from the stage before.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[s] <= '0;
                end else begin
                    stg_q[s] <= stg_q[s-1];
                end
            end
        end
    end

    // Compare the decode fields against every tracked destination.
    always_comb begin
        raw_hit = 1'b0;
        waw_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (stg_q[i].vld && stg_q[i].dst_en) begin
                if (q_dst_en && (stg_q[i].dst == q_dst)) begin
                    waw_hit = 1'b1;
                end
                if (i < RAW_STAGES) begin
                    if (q_src1_en && (stg_q[i].dst == q_src1)) raw_hit = 1'b1;
                    if (q_src2_en && (stg_q[i].dst == q_src2)) raw_hit = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ilk_div_track.sv
// Occupancy tracker for the unpipelined divider.
// A down-counter loaded with LAT on start keeps the unit busy until it
// reaches zero, giving an initiation interval of LAT+1. While busy, the
// held destination is pending for both RAW and WAW. Assumes start is
// only raised when busy is low.
module ilk_div_track
    import ilk_pkg::*;
#(
    parameter int LAT = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_dst_en,
    input  logic [REG_W-1:0] start_dst,
    input  logic [REG_W-1:0] q_src1,
    input  logic             q_src1_en,
    input  logic [REG_W-1:0] q_src2,
    input  logic             q_src2_en,
    input  logic [REG_W-1:0] q_dst,
    input  logic             q_dst_en,
    output logic             busy,
    output logic             raw_hit,
    output logic             waw_hit
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]    cnt_q;
    logic             dst_en_q;
    logic [REG_W-1:0] dst_q;

    // Count down the remaining occupancy; reload on a new divide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Capture the destination of the divide in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_en_q <= 1'b0;
            dst_q    <= '0;
        end else if (start) begin
            dst_en_q <= start_dst_en;
            dst_q    <= start_dst;
        end
    end

    assign busy = (cnt_q != '0);

    // Pending-destination comparisons while the divider is occupied.
    always_comb begin
        raw_hit = busy && dst_en_q &&
                  ((q_src1_en && (q_src1 == dst_q)) || (q_src2_en && (q_src2 == dst_q)));
        waw_hit = busy && dst_en_q && q_dst_en && (q_dst == dst_q);
    end

    // R3: a new divide never lands on an occupied divider.
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R3: occupancy drains by exactly one per cycle.
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/ilk_wb_resv.sv
// Booking vector for the single register-file write port.
// Bit j means a write-back happens j cycles from now; the vector shifts
// down by one each cycle. A claim books offset claim_ofs. Assumes the
// caller only claims a free offset between 1 and SLOTS.
module ilk_wb_resv #(
    parameter int SLOTS = 26,
    localparam int OW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim,
    input  logic [OW-1:0] claim_ofs,
    output logic          taken,
    output logic          wb_now
);

    localparam int RW = SLOTS + 1;

    logic [RW-1:0] resv_q;
    logic [RW-1:0] resv_d;
    logic [RW-1:0] claim_vec;

    // One-hot of the slot one position below the claimed offset (post-shift).
    assign claim_vec = claim ? (RW'(1) << (claim_ofs - OW'(1))) : '0;
    assign resv_d    = {1'b0, resv_q[RW-1:1]} | claim_vec;

    // Advance the booking vector by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    assign taken  = resv_q[claim_ofs];
    assign wb_now = resv_q[0];

    // R6: a claimed write-back cycle is never booked twice.
    a_r6_no_double_book: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> !resv_q[claim_ofs]);

endmodule

// File: rtl/ilk_issue_interlock.sv
// Issue interlock for an in-order pipeline with multi-latency execute units.
// Combines per-unit stage trackers, the divider occupancy tracker and the
// write-port booking vector into issue/stall decisions for the decode
// instruction. Assumes operands are read in decode (no WAR check) and that
// the divider latency is the largest latency.
module ilk_issue_interlock
    import ilk_pkg::*;
#(
    parameter int LAT_INT  = 0,
    parameter int LAT_LOAD = 1,
    parameter int LAT_FADD = 3,
    parameter int LAT_MUL  = 6,
    parameter int LAT_DIV  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [2:0]         dec_cls,
    input  logic [REG_W-1:0]   dec_dst,
    input  logic               dec_dst_en,
    input  logic [REG_W-1:0]   dec_src1,
    input  logic               dec_src1_en,
    input  logic [REG_W-1:0]   dec_src2,
    input  logic               dec_src2_en,
    output logic               issue,
    output logic               stall,
    output logic [CAUSE_W-1:0] stall_cause,
    output logic               wb_now
);

    localparam int NPIPE   = 4;
    localparam int LAT_MAX = imax(imax(imax(LAT_INT, LAT_LOAD), imax(LAT_FADD, LAT_MUL)), LAT_DIV);
    localparam int SLOTS   = LAT_MAX + 2;
    localparam int OW      = $clog2(SLOTS + 1);
    localparam int PIPE_LAT [NPIPE] = '{LAT_INT, LAT_LOAD, LAT_FADD, LAT_MUL};

    unit_cls_e         cls_n;
    logic [NPIPE-1:0]  raw_p;
    logic [NPIPE-1:0]  waw_p;
    logic              div_busy;
    logic              div_raw;
    logic              div_waw;
    logic              wb_taken;
    logic [OW-1:0]     wb_ofs;
    logic              h_busy;
    logic              h_raw;
    logic              h_waw;
    logic              h_wbp;
    logic              any_haz;

    // Fold reserved class codes onto the integer unit.
    assign cls_n = (dec_cls > 3'd4) ? CLS_INT : unit_cls_e'(dec_cls);

    // Write-back offset from issue for the decode class.
    always_comb begin
        unique case (cls_n)
            CLS_LOAD: wb_ofs = OW'(LAT_LOAD + 2);
            CLS_FADD: wb_ofs = OW'(LAT_FADD + 2);
            CLS_MUL:  wb_ofs = OW'(LAT_MUL + 2);
            CLS_DIV:  wb_ofs = OW'(LAT_DIV + 2);
            default:  wb_ofs = OW'(LAT_INT + 2);
        endcase
    end

    // One stage tracker per pipelined unit, depth = latency + 1.
    for (genvar g = 0; g < NPIPE; g++) begin : g_unit
        ilk_stage_pipe #(
            .DEPTH      (PIPE_LAT[g] + 1),
            .RAW_STAGES (PIPE_LAT[g])
        ) u_pipe (
            .clk         (clk),
            .rst_n       (rst_n),
            .push        (issue && (cls_n == unit_cls_e'(3'(g)))),
            .push_dst_en (dec_dst_en),
            .push_dst    (dec_dst),
            .q_src1      (dec_src1),
            .q_src1_en   (dec_src1_en),
            .q_src2      (dec_src2),
            .q_src2_en   (dec_src2_en),
            .q_dst       (dec_dst),
            .q_dst_en    (dec_dst_en),
            .raw_hit     (raw_p[g]),
            .waw_hit     (waw_p[g])
        );
    end

    ilk_div_track #(
        .LAT (LAT_DIV)
    ) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (issue && (cls_n == CLS_DIV)),
        .start_dst_en (dec_dst_en),
        .start_dst    (dec_dst),
        .q_src1       (dec_src1),
        .q_src1_en    (dec_src1_en),
        .q_src2       (dec_src2),
        .q_src2_en    (dec_src2_en),
        .q_dst        (dec_dst),
        .q_dst_en     (dec_dst_en),
        .busy         (div_busy),
        .raw_hit      (div_raw),
        .waw_hit      (div_waw)
    );

    ilk_wb_resv #(
        .SLOTS (SLOTS)
    ) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (issue && dec_dst_en),
        .claim_ofs (wb_ofs),
        .taken     (wb_taken),
        .wb_now    (wb_now)
    );

    // Gather hazards and form the decode decision.
    always_comb begin
        h_busy  = div_busy && (cls_n == CLS_DIV);
        h_raw   = (|raw_p) || div_raw;
        h_waw   = (|waw_p) || div_waw;
        h_wbp   = dec_dst_en && wb_taken;
        any_haz = h_busy || h_raw || h_waw || h_wbp;
        issue   = dec_valid && !any_haz;
        stall   = dec_valid && any_haz;
        stall_cause = dec_valid ? {h_wbp, h_waw, h_raw, h_busy} : '0;
    end

    // R3: an accepted divide leaves the divider occupied next cycle.
    a_r3_div_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (cls_n == CLS_DIV)) |=> div_busy);

    // R6: a write-back booked at the integer offset shows up on the port.
    a_r6_int_wb_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_dst_en && (cls_n == CLS_INT) && (LAT_INT == 0)) |=> ##1 wb_now);

endmodule

// File: tb/ilk_issue_interlock_tb.sv
// Directed bench for the issue interlock; one task per scenario.
module ilk_issue_interlock_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] K_INT  = 3'd0;
    localparam logic [2:0] K_LOAD = 3'd1;
    localparam logic [2:0] K_FADD = 3'd2;
    localparam logic [2:0] K_MUL  = 3'd3;
    localparam logic [2:0] K_DIV  = 3'd4;

    localparam logic [3:0] C_NONE = 4'b0000;
    localparam logic [3:0] C_BUSY = 4'b0001;
    localparam logic [3:0] C_RAW  = 4'b0010;
    localparam logic [3:0] C_WAW  = 4'b0100;
    localparam logic [3:0] C_WBP  = 4'b1000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_valid;
    logic [2:0] dec_cls;
    logic [4:0] dec_dst;
    logic       dec_dst_en;
    logic [4:0] dec_src1;
    logic       dec_src1_en;
    logic [4:0] dec_src2;
    logic       dec_src2_en;
    logic       issue;
    logic       stall;
    logic [3:0] stall_cause;
    logic       wb_now;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ilk_issue_interlock dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_valid   (dec_valid),
        .dec_cls     (dec_cls),
        .dec_dst     (dec_dst),
        .dec_dst_en  (dec_dst_en),
        .dec_src1    (dec_src1),
        .dec_src1_en (dec_src1_en),
        .dec_src2    (dec_src2),
        .dec_src2_en (dec_src2_en),
        .issue       (issue),
        .stall       (stall),
        .stall_cause (stall_cause),
        .wb_now      (wb_now)
    );

    task automatic present(input logic [2:0] c, input logic [4:0] d, input logic de,
                           input logic [4:0] s1, input logic s1e,
                           input logic [4:0] s2, input logic s2e);
        dec_valid = 1'b1; dec_cls = c; dec_dst = d; dec_dst_en = de;
        dec_src1 = s1; dec_src1_en = s1e; dec_src2 = s2; dec_src2_en = s2e;
        #1;
    endtask

    task automatic idle();
        dec_valid = 1'b0; dec_cls = K_INT; dec_dst = '0; dec_dst_en = 1'b0;
        dec_src1 = '0; dec_src1_en = 1'b0; dec_src2 = '0; dec_src2_en = 1'b0;
        #1;
    endtask

    // Move to the next cycle: inputs change just after the falling edge.
    task automatic adv();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic chk_dec(input string tag, input logic e_iss, input logic e_stl,
                           input logic [3:0] e_cause);
        n_chk++;
        if ({issue, stall, stall_cause} !== {e_iss, e_stl, e_cause}) begin
            n_fail++;
            $display("FAIL %s: issue/stall/cause = %b/%b/%b expected %b/%b/%b",
                     tag, issue, stall, stall_cause, e_iss, e_stl, e_cause);
        end
    endtask

    task automatic chk_wb(input string tag, input logic e_wb);
        n_chk++;
        if (wb_now !== e_wb) begin
            n_fail++;
            $display("FAIL %s: wb_now = %b expected %b", tag, wb_now, e_wb);
        end
    endtask

    // R1 and R2: clean state after reset, idle decode, mid-run reset.
    task automatic t_reset();
        do_reset();
        chk_dec("R1 idle after reset", 1'b0, 1'b0, C_NONE);
        chk_wb("R1 no booked write-back", 1'b0);
        present(K_INT, 5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1);
        chk_dec("R1 first instruction issues", 1'b1, 1'b0, C_NONE);
        present(K_DIV, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        adv();
        present(K_DIV, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        adv();
        dec_valid = 1'b0; dec_src1 = 5'd9; dec_src1_en = 1'b1; #1;
        chk_dec("R2 no valid no outputs", 1'b0, 1'b0, C_NONE);
        do_reset();
        present(K_DIV, 5'd9, 1'b1, 5'd9, 1'b1, 5'd0, 1'b0);
        chk_dec("R1 divider free after reset", 1'b1, 1'b0, C_NONE);
    endtask

    // R4: reader of a class producer waits exactly its latency.
    task automatic t_raw(input logic [2:0] pcls, input int lat, input string tag);
        do_reset();
        present(pcls, 5'd2, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec({tag, " R4 producer issues"}, 1'b1, 1'b0, C_NONE);
        for (int k = 1; k <= lat; k++) begin
            adv();
            present(K_INT, 5'd0, 1'b0, 5'd2, 1'b1, 5'd0, 1'b0);
            chk_dec({tag, " R4 reader held"}, 1'b0, 1'b1, C_RAW);
        end
        adv();
        present(K_INT, 5'd0, 1'b0, 5'd30, 1'b0, 5'd2, 1'b1);
        chk_dec({tag, " R4 reader released"}, 1'b1, 1'b0, C_NONE);
    endtask

    // R3: second divide waits for the 25-cycle repeat interval.
    task automatic t_div_busy();
        do_reset();
        present(K_DIV, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R3 first divide", 1'b1, 1'b0, C_NONE);
        for (int k = 1; k <= 24; k++) begin
            adv();
            present(K_DIV, 5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
            chk_dec("R3 divider busy", 1'b0, 1'b1, C_BUSY);
        end
        adv();
        present(K_DIV, 5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R3 divider accepts at 25", 1'b1, 1'b0, C_NONE);
    endtask

    // R5 and R7: WAW behind a multiply, unused fields ignored.
    task automatic t_waw();
        do_reset();
        present(K_MUL, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R5 multiply issues", 1'b1, 1'b0, C_NONE);
        adv();
        present(K_INT, 5'd6, 1'b0, 5'd6, 1'b0, 5'd6, 1'b0);
        chk_dec("R7 unused fields no hazard", 1'b1, 1'b0, C_NONE);
        for (int k = 2; k <= 7; k++) begin
            adv();
            present(K_FADD, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
            chk_dec("R5 same destination held", 1'b0, 1'b1,
                    (k + 5 == 8) ? (C_WAW | C_WBP) : C_WAW);
            if (k == 3) chk_wb("R7 unused destination books nothing", 1'b0);
        end
        adv();
        present(K_FADD, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R5 released after multiply leaves", 1'b1, 1'b0, C_NONE);
        chk_wb("R6 multiply writes at t+8", 1'b1);
    endtask

    // R6: write-port conflicts and the visible write-back schedule.
    task automatic t_wbp();
        do_reset();
        present(K_LOAD, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R6 load issues", 1'b1, 1'b0, C_NONE);
        adv();
        present(K_INT, 5'd2, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R6 integer hits load write slot", 1'b0, 1'b1, C_WBP);
        adv();
        present(K_INT, 5'd2, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R6 integer issues next cycle", 1'b1, 1'b0, C_NONE);
        chk_wb("R6 no write at t+2", 1'b0);
        adv(); idle();
        chk_wb("R6 load writes at t+3", 1'b1);
        adv();
        chk_wb("R6 integer writes at t+4", 1'b1);
        adv();
        chk_wb("R6 port idle at t+5", 1'b0);
        do_reset();
        present(K_MUL, 5'd7, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        adv(); idle();
        adv();
        adv();
        present(K_FADD, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R6 add collides with multiply", 1'b0, 1'b1, C_WBP);
        adv();
        present(K_FADD, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R6 add issues one later", 1'b1, 1'b0, C_NONE);
    endtask

    // R8: a stalled then replaced instruction leaves no trace.
    task automatic t_bubble();
        do_reset();
        present(K_MUL, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        adv();
        present(K_FADD, 5'd12, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0);
        chk_dec("R8 add held by RAW", 1'b0, 1'b1, C_RAW);
        adv();
        present(K_INT, 5'd12, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        chk_dec("R8 replacement sees no phantom WAW", 1'b1, 1'b0, C_NONE);
        adv(); idle();
        chk_wb("R8 nothing at t+3", 1'b0);
        adv();
        chk_wb("R8 replacement writes at t+4", 1'b1);
        adv();
        adv();
        chk_wb("R8 stalled add booked nothing", 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        t_reset();
        t_raw(K_INT,  0,  "int");
        t_raw(K_LOAD, 1,  "load");
        t_raw(K_FADD, 3,  "fadd");
        t_raw(K_MUL,  6,  "mul");
        t_raw(K_DIV,  24, "div");
        t_raw(3'd6,   0,  "reserved");
        t_div_busy();
        t_waw();
        t_wbp();
        t_bubble();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule